// File: doc/BRIEF.md
# Ethernet Test Frame Generator

This block is a transmit-side test source placed in front of a gigabit PHY datapath. While its enable input is set, it takes the byte-wide transmit path away from the MAC completely. It then emits layer-2 Ethernet frames on a GMII-style output (`txd`, `tx_en`, `tx_er`). Each frame carries a programmable destination address and source address, a selectable size, and a payload made of one 16-bit word repeated. The frame check sequence is either correct or deliberately broken. A selectable idle gap separates consecutive frames.

Software starts a run with a one-cycle set pulse on the run bit. In continuous mode the generator sends frames back to back until the run bit is cleared. In burst mode the run bit clears itself after a fixed number of frames, 30,000,000 by default. A frame that has begun always finishes. The MAC receive path stays connected to the PHY receive side while the generator is enabled. A separate isolate input forces the MAC receive outputs to zero.

Top module: `testframe_gen`

## Requirements
- R1: With `gen_en` low, `txd`/`tx_en`/`tx_er` repeat `mac_txd`/`mac_tx_en`/`mac_tx_er` one clock later. With `gen_en` high, the MAC transmit inputs are ignored, and `tx_en` is high only while a generated frame is being sent.
- R2: `mac_rxd`/`mac_rx_dv` repeat `phy_rxd`/`phy_rx_dv` one clock later regardless of `gen_en`. While `rx_isolate` is high they are forced to zero one clock later.
- R3: A generated frame starts with seven bytes 0x55 and then 0xD5. These are followed by the six `dst_addr` bytes (bits 47:40 first) and the six `src_addr` bytes in the same order. Next comes a two-byte length field, high byte first, equal to the payload length.
- R4: `big_frame`=0 gives a 64-byte frame, from the first address byte through the FCS, with a 46-byte payload. `big_frame`=1 gives 1518 bytes with a 1500-byte payload. The payload alternates `pattern[15:8]`, `pattern[7:0]`, starting with the high byte.
- R5: The FCS is the IEEE 802.3 CRC-32 over the addresses, length and payload. It uses the reflected polynomial 0xEDB88320 with seed 0xFFFFFFFF, the final value is complemented, and the bytes are sent least significant byte first. With `bad_fcs`=1, each FCS byte is the bitwise inverse of the correct one.
- R6: A `run_set` pulse sets `running` and starts frames while `gen_en` is high, and `run_clr` clears `running`. With `continuous`=0, `running` clears by itself after BURST_PKTS frames.
- R7: Between frames of one run, `tx_en` stays low for exactly 12 clocks (`long_gap`=0) or 1024 clocks (`long_gap`=1).
- R8: Clearing `running` in the middle of a frame does not shorten that frame, and no further frame starts afterwards.
- R9: After reset, `running`, `tx_en`, `tx_er` and `mac_rx_dv` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | byte clock |
| rst | input | 1 | synchronous active-high reset |
| gen_en | input | 1 | selects the generator as the transmit source |
| rx_isolate | input | 1 | forces MAC receive outputs to zero |
| run_set | input | 1 | one-cycle pulse that sets the run bit |
| run_clr | input | 1 | one-cycle pulse that clears the run bit |
| continuous | input | 1 | 1: run until cleared, 0: fixed burst |
| dst_addr | input | 48 | destination address |
| src_addr | input | 48 | source address |
| big_frame | input | 1 | 0: 64-byte frame, 1: 1518-byte frame |
| long_gap | input | 1 | 0: 12-byte gap, 1: 1024-byte gap |
| bad_fcs | input | 1 | send the inverted FCS |
| pattern | input | 16 | payload word |
| mac_txd | input | 8 | MAC transmit data |
| mac_tx_en | input | 1 | MAC transmit enable |
| mac_tx_er | input | 1 | MAC transmit error |
| phy_rxd | input | 8 | PHY receive data |
| phy_rx_dv | input | 1 | PHY receive valid |
| txd | output | 8 | transmit data toward the PHY |
| tx_en | output | 1 | transmit enable toward the PHY |
| tx_er | output | 1 | transmit error toward the PHY |
| mac_rxd | output | 8 | receive data toward the MAC |
| mac_rx_dv | output | 1 | receive valid toward the MAC |
| running | output | 1 | run bit |

## Verification
The bench captures whole frames and compares every byte with its own model, and it recomputes the CRC bit by bit. A header indexing slip, a payload that starts on the low byte, or a CRC sent most significant byte first would each produce a byte mismatch. A gap counter that is off by one would show up as 11 or 13 idle clocks. A burst counter compared against the wrong limit would send two or four frames instead of three. A stop that cuts the frame short would give a length other than 72 bytes, and MAC data leaking through while the generator is idle would raise `tx_en`.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_HDR, PH_PAY, PH_FCS, PH_GAP
  } phase_t;

  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/tpg_crc.sv
module tpg_crc
  import tpg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  d,
  output logic [31:0] crc_q
);
  always_ff @(posedge clk) begin
    if (rst || init) crc_q <= CRC_SEED;
    else if (en)     crc_q <= crc_step(crc_q, d);
  end

  AST_CRC_SEEDED: assert property (@(posedge clk) disable iff (rst)
    init |=> (crc_q == CRC_SEED)); // R5
endmodule

// File: rtl/tpg_seq.sv
module tpg_seq
  import tpg_pkg::*;
#(
  parameter int BURST_PKTS  = 30_000_000,
  parameter int SMALL_FRAME = 64,
  parameter int BIG_FRAME   = 1518,
  parameter int SHORT_GAP   = 12,
  parameter int LONG_GAP    = 1024,
  parameter int ADDR_W      = 48,
  parameter int PAT_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_en,
  input  logic              run_set,
  input  logic              run_clr,
  input  logic              continuous,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic              big_frame,
  input  logic              long_gap,
  input  logic              bad_fcs,
  input  logic [PAT_W-1:0]  pattern,
  input  logic [31:0]       crc_q,
  output logic              running,
  output logic [7:0]        byte_d,
  output logic              byte_v,
  output logic              crc_init,
  output logic              crc_en
);
  localparam int HDR_BYTES = 2 * (ADDR_W / 8) + 2;
  localparam int OVERHEAD  = HDR_BYTES + 4;
  localparam int MAX_CNT   = (BIG_FRAME > LONG_GAP) ? BIG_FRAME : LONG_GAP;
  localparam int CNT_W     = $clog2(MAX_CNT + 1);
  localparam int PKT_W     = $clog2(BURST_PKTS + 1);
  localparam int HDR_W     = 8 * HDR_BYTES;

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [PKT_W-1:0]  pkt_cnt;
  logic [ADDR_W-1:0] da_q, sa_q;
  logic [PAT_W-1:0]  pat_q;
  logic              bad_q;
  logic [CNT_W-1:0]  plen_q, gap_q;
  logic              start_frame;
  logic [HDR_W-1:0]  hdr_vec, hdr_sh;
  logic [31:0]       fcs_sh;

  always_comb begin
    start_frame = running && gen_en &&
                  ((phase == PH_IDLE) || (phase == PH_GAP && cnt == gap_q - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      running <= 1'b0;
      pkt_cnt <= '0;
      da_q    <= '0;
      sa_q    <= '0;
      pat_q   <= '0;
      bad_q   <= 1'b0;
      plen_q  <= CNT_W'(SMALL_FRAME - OVERHEAD);
      gap_q   <= CNT_W'(SHORT_GAP);
    end else begin
      if (run_clr) running <= 1'b0;
      else if (run_set) begin
        running <= 1'b1;
        pkt_cnt <= '0;
      end
      if (start_frame) begin
        da_q   <= dst_addr;
        sa_q   <= src_addr;
        pat_q  <= pattern;
        bad_q  <= bad_fcs;
        plen_q <= big_frame ? CNT_W'(BIG_FRAME - OVERHEAD) : CNT_W'(SMALL_FRAME - OVERHEAD);
        gap_q  <= long_gap ? CNT_W'(LONG_GAP) : CNT_W'(SHORT_GAP);
      end
      cnt <= cnt + 1'b1;
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (start_frame) phase <= PH_PRE;
        end
        PH_PRE: if (cnt == CNT_W'(7)) begin
          phase <= PH_HDR;
          cnt   <= '0;
        end
        PH_HDR: if (cnt == CNT_W'(HDR_BYTES - 1)) begin
          phase <= PH_PAY;
          cnt   <= '0;
        end
        PH_PAY: if (cnt == plen_q - 1'b1) begin
          phase <= PH_FCS;
          cnt   <= '0;
        end
        PH_FCS: if (cnt == CNT_W'(3)) begin
          phase <= PH_GAP;
          cnt   <= '0;
          if (!continuous) begin
            if (pkt_cnt == PKT_W'(BURST_PKTS - 1)) begin
              running <= 1'b0;
              pkt_cnt <= '0;
            end else begin
              pkt_cnt <= pkt_cnt + 1'b1;
            end
          end
        end
        PH_GAP: if (cnt == gap_q - 1'b1) begin
          cnt   <= '0;
          phase <= start_frame ? PH_PRE : PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    hdr_vec  = {da_q, sa_q, 16'(plen_q)};
    hdr_sh   = hdr_vec << (8 * cnt);
    fcs_sh   = crc_q >> (8 * cnt[1:0]);
    byte_d   = 8'h00;
    byte_v   = 1'b1;
    case (phase)
      PH_PRE:  byte_d = (cnt == CNT_W'(7)) ? SFD_BYTE : PRE_BYTE;
      PH_HDR:  byte_d = hdr_sh[HDR_W-1 -: 8];
      PH_PAY:  byte_d = cnt[0] ? pat_q[7:0] : pat_q[15:8];
      PH_FCS:  byte_d = bad_q ? fcs_sh[7:0] : ~fcs_sh[7:0];
      default: byte_v = 1'b0;
    endcase
    crc_init = (phase == PH_PRE);
    crc_en   = (phase == PH_HDR) || (phase == PH_PAY);
  end

  AST_SFD_THEN_HDR: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PRE && cnt == CNT_W'(7)) |=> (phase == PH_HDR)); // R3
  AST_FRAME_NOT_CUT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PAY) |=> (phase == PH_PAY || phase == PH_FCS)); // R8
  AST_RUN_SETS: assert property (@(posedge clk) disable iff (rst)
    (run_set && !run_clr && phase != PH_FCS) |=> running); // R6
  AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    run_clr |=> !running); // R6
  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (rst)
    pkt_cnt < PKT_W'(BURST_PKTS)); // R6
endmodule

// File: rtl/tpg_txmux.sv
module tpg_txmux (
  input  logic       clk,
  input  logic       rst,
  input  logic       gen_en,
  input  logic       rx_isolate,
  input  logic [7:0] gen_d,
  input  logic       gen_v,
  input  logic [7:0] mac_txd,
  input  logic       mac_tx_en,
  input  logic       mac_tx_er,
  input  logic [7:0] phy_rxd,
  input  logic       phy_rx_dv,
  output logic [7:0] txd,
  output logic       tx_en,
  output logic       tx_er,
  output logic [7:0] mac_rxd,
  output logic       mac_rx_dv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      txd       <= '0;
      tx_en     <= 1'b0;
      tx_er     <= 1'b0;
      mac_rxd   <= '0;
      mac_rx_dv <= 1'b0;
    end else begin
      txd       <= gen_en ? gen_d : mac_txd;
      tx_en     <= gen_en ? gen_v : mac_tx_en;
      tx_er     <= gen_en ? 1'b0  : mac_tx_er;
      mac_rxd   <= rx_isolate ? 8'h00 : phy_rxd;
      mac_rx_dv <= rx_isolate ? 1'b0  : phy_rx_dv;
    end
  end

  AST_MAC_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (gen_en && !gen_v) |=> (!tx_en && !tx_er)); // R1
  AST_RX_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    rx_isolate |=> (!mac_rx_dv && mac_rxd == 8'h00)); // R2
endmodule

// File: rtl/testframe_gen.sv
module testframe_gen #(
  parameter int BURST_PKTS = 30_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        gen_en,
  input  logic        rx_isolate,
  input  logic        run_set,
  input  logic        run_clr,
  input  logic        continuous,
  input  logic [47:0] dst_addr,
  input  logic [47:0] src_addr,
  input  logic        big_frame,
  input  logic        long_gap,
  input  logic        bad_fcs,
  input  logic [15:0] pattern,
  input  logic [7:0]  mac_txd,
  input  logic        mac_tx_en,
  input  logic        mac_tx_er,
  input  logic [7:0]  phy_rxd,
  input  logic        phy_rx_dv,
  output logic [7:0]  txd,
  output logic        tx_en,
  output logic        tx_er,
  output logic [7:0]  mac_rxd,
  output logic        mac_rx_dv,
  output logic        running
);
  logic [7:0]  gen_d;
  logic        gen_v, crc_init, crc_en;
  logic [31:0] crc_q;

  tpg_seq #(.BURST_PKTS(BURST_PKTS)) u_seq (
    .clk(clk), .rst(rst), .gen_en(gen_en), .run_set(run_set), .run_clr(run_clr),
    .continuous(continuous), .dst_addr(dst_addr), .src_addr(src_addr),
    .big_frame(big_frame), .long_gap(long_gap), .bad_fcs(bad_fcs),
    .pattern(pattern), .crc_q(crc_q), .running(running), .byte_d(gen_d),
    .byte_v(gen_v), .crc_init(crc_init), .crc_en(crc_en)
  );

  tpg_crc u_crc (
    .clk(clk), .rst(rst), .init(crc_init), .en(crc_en), .d(gen_d), .crc_q(crc_q)
  );

  tpg_txmux u_mux (
    .clk(clk), .rst(rst), .gen_en(gen_en), .rx_isolate(rx_isolate),
    .gen_d(gen_d), .gen_v(gen_v), .mac_txd(mac_txd), .mac_tx_en(mac_tx_en),
    .mac_tx_er(mac_tx_er), .phy_rxd(phy_rxd), .phy_rx_dv(phy_rx_dv),
    .txd(txd), .tx_en(tx_en), .tx_er(tx_er), .mac_rxd(mac_rxd), .mac_rx_dv(mac_rx_dv)
  );
endmodule

// File: tb/tb_testframe_gen.sv
`timescale 1ns/1ps
module tb_testframe_gen;
  localparam int BURST = 3;
  localparam logic [47:0] DA = 48'h0123_4567_89AB;
  localparam logic [47:0] SA = 48'h02CA_FEBE_EF10;
  // vector: {big_frame, long_gap, bad_fcs, pattern}
  localparam int NVEC = 4;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 16'hA55A},
    {1'b0, 1'b1, 1'b1, 16'h0F0F},
    {1'b1, 1'b0, 1'b0, 16'h1234},
    {1'b1, 1'b0, 1'b1, 16'hFFFF}
  };

  logic clk = 0, rst = 1;
  logic gen_en = 0, rx_isolate = 0, run_set = 0, run_clr = 0, continuous = 1;
  logic [47:0] dst_addr = DA, src_addr = SA;
  logic big_frame = 0, long_gap = 0, bad_fcs = 0;
  logic [15:0] pattern = 16'h0;
  logic [7:0] mac_txd = 0, phy_rxd = 0;
  logic mac_tx_en = 0, mac_tx_er = 0, phy_rx_dv = 0;
  logic [7:0] txd, mac_rxd;
  logic tx_en, tx_er, mac_rx_dv, running;

  int checks = 0, failures = 0, cycles = 0;
  logic [7:0] frm [0:1599];
  int flen;

  testframe_gen #(.BURST_PKTS(BURST)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
        finish_run();
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 8; b++) begin
      logic fb = r[0] ^ d[b];
      r = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  task automatic pulse_set();
    run_set = 1; @(negedge clk); run_set = 0;
  endtask

  // capture one frame; pulse run_clr when byte index clr_at is seen
  task automatic capture(input int clr_at);
    int guard = 0;
    while (!tx_en && guard < 5000) begin @(negedge clk); guard++; end
    flen = 0;
    while (tx_en && flen < 1600) begin
      frm[flen] = txd;
      run_clr = (flen == clr_at);
      flen++;
      @(negedge clk);
    end
    run_clr = 0;
  endtask

  task automatic idle_cycles(output int n, input int lim);
    n = 0;
    while (!tx_en && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic check_frame(input logic [18:0] v);
    int plen = v[18] ? 1500 : 46;
    int bad_pre = 0, bad_hdr = 0, bad_pay = 0;
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] fcs_exp, fcs_got;
    logic [111:0] hdr = {DA, SA, 16'(plen)};
    check("R4 frame length", flen, plen + 26);
    for (int i = 0; i < 8; i++)
      if (frm[i] != ((i == 7) ? 8'hD5 : 8'h55)) bad_pre++;
    for (int i = 0; i < 14; i++)
      if (frm[8+i] != hdr[111-8*i -: 8]) bad_hdr++;
    for (int i = 0; i < plen; i++)
      if (frm[22+i] != ((i % 2) ? v[7:0] : v[15:8])) bad_pay++;
    for (int i = 8; i < 22 + plen; i++) c = ref_crc(c, frm[i]);
    fcs_exp = v[16] ? c : ~c;
    fcs_got = {frm[25+plen], frm[24+plen], frm[23+plen], frm[22+plen]};
    check("R3 preamble/SFD mismatches", bad_pre, 0);
    check("R3 header mismatches", bad_hdr, 0);
    check("R4 payload mismatches", bad_pay, 0);
    check("R5 FCS", fcs_got, fcs_exp);
  endtask

  initial begin
    int n, frames;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    check("R9 running after reset", running, 0);
    check("R9 tx_en after reset", tx_en, 0);
    check("R9 mac_rx_dv after reset", mac_rx_dv, 0);

    // R1 passthrough with generator off
    mac_txd = 8'hA5; mac_tx_en = 1; mac_tx_er = 1;
    @(negedge clk);
    check("R1 passthrough txd", txd, 8'hA5);
    check("R1 passthrough tx_er", tx_er, 1);
    // R1 MAC ignored when generator enabled but idle
    gen_en = 1;
    @(negedge clk);
    check("R1 mac ignored tx_en", tx_en, 0);
    check("R1 mac ignored tx_er", tx_er, 0);
    mac_tx_en = 0; mac_tx_er = 0;

    // R2 receive path
    phy_rxd = 8'h3C; phy_rx_dv = 1;
    @(negedge clk);
    check("R2 rx pass data", mac_rxd, 8'h3C);
    check("R2 rx pass dv", mac_rx_dv, 1);
    rx_isolate = 1;
    @(negedge clk);
    check("R2 rx isolated dv", mac_rx_dv, 0);
    check("R2 rx isolated data", mac_rxd, 0);
    rx_isolate = 0; phy_rx_dv = 0;

    // table walk: R3 R4 R5 R7
    for (int k = 0; k < NVEC; k++) begin
      {big_frame, long_gap, bad_fcs, pattern} = VEC[k];
      continuous = 1;
      pulse_set();
      check("R6 running after set", running, 1);
      mac_txd = 8'hEE; mac_tx_en = 1;  // must not leak (R1)
      capture(-1);
      check_frame(VEC[k]);
      idle_cycles(n, 2000);
      check("R7 gap length", n, VEC[k][17] ? 1024 : 12);
      capture(10);
      check("R8 frame length after clear", flen, (VEC[k][18] ? 1500 : 46) + 26);
      idle_cycles(n, 1200);
      check("R8 no frame after clear", tx_en, 0);
      mac_tx_en = 0;
    end

    // R8 stop mid-payload of a short frame
    {big_frame, long_gap, bad_fcs, pattern} = VEC[0];
    pulse_set();
    capture(40);
    check_frame(VEC[0]);
    check("R8 running cleared", running, 0);
    idle_cycles(n, 300);
    check("R8 idle cycles after stop", n, 300);

    // R6 burst mode
    continuous = 0;
    pulse_set();
    frames = 0;
    for (int f = 0; f < BURST + 2; f++) begin
      idle_cycles(n, 300);
      if (tx_en) begin frames++; capture(-1); end
    end
    check("R6 burst frame count", frames, BURST);
    check("R6 run bit self-cleared", running, 0);

    finish_run();
  end
endmodule